// File: doc/BRIEF.md
# Frame-Synchronous Word Scrambler

This block whitens a stream of transport-frame words, 64 bits per clock, by XORing each word with a keystream from a 16-bit linear feedback generator built on the polynomial 1 + x + x^3 + x^12 + x^16. The keystream is frame-synchronous. At each frame start the generator restarts from an all-ones seed. The alignment bytes at the head of the frame pass through untouched, and scrambling begins on the first bit after them. XOR with the same keystream undoes itself, so one instance scrambles on the transmit side and another identical instance descrambles on the receive side.

Each word arrives with a word-valid strobe and a frame-start marker. The block registers the result once and presents it with sideband signals delayed to match. A per-word enable lets the data through unchanged while the generator still follows the frame position. A diagnostic input drops the x^3 term from the feedback for as long as it is held. A far-end descrambler using the correct polynomial then produces garbage, which exercises the checks downstream.

Top module: `otn_frame_scrambler`

## Requirements
- R1: The keystream obeys k(n+16) = k(n+15) ^ k(n+13) ^ k(n+4) ^ k(n). In state terms, the next state is {S[14:0], S[15]^S[11]^S[2]^S[0]} and the emitted bit is S[15]. Keystream bits go to data bits in descending order, so bit 63 of a word receives the earliest key bit.
- R2: On a valid word with in_sof high, the upper 6 bytes (bits 63:16) pass through unchanged. Bits 15:0 are XORed with the first 16 key bits from the all-ones seed, so an all-zero frame-start word leaves as 64'h000000000000FFFF.
- R3: Every valid word that follows continues the keystream where the previous valid word ended. A word with in_valid low leaves on out_data unchanged, does not advance the generator, and has its in_sof ignored.
- R4: out_data, out_valid and out_sof appear one clock after the input word. out_valid equals the delayed in_valid, and out_sof equals the delayed (in_sof AND in_valid).
- R5: With scr_en low, out_data equals in_data after the same single clock. The generator still advances on valid words, so raising scr_en in mid-frame scrambles with the keystream that an always-enabled path would have used at that position.
- R6: While corrupt_en is high, the feedback drops the S[2] term (x^3) for the words presented in that cycle. Output then departs from the nominal keystream once feedback bits reach the output.
- R7: Passing a scrambled frame through the block a second time with the same frame-start positions returns the original words.
- R8: During reset the outputs are zero. The generator leaves reset holding all ones, so a valid word seen before any frame start is scrambled with the keystream from the seed (its top 16 key bits are all ones).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | 64 | Input word, bit 63 first on the line |
| in_sof | input | 1 | Input word carries the frame alignment bytes |
| in_valid | input | 1 | Input word is valid |
| scr_en | input | 1 | Apply the keystream to this word |
| corrupt_en | input | 1 | Use the corrupted feedback polynomial |
| out_data | output | 64 | Scrambled or passed word |
| out_sof | output | 1 | Delayed frame-start marker |
| out_valid | output | 1 | Delayed word-valid strobe |

## Verification
The bound checker verifies the port relations that hold on every cycle. It checks the one-clock delay of the valid and frame-start sidebands, the untouched alignment bytes on frame-start words, and the exact pass-through of idle words and of words presented with the enable low. The keystream cannot be seen at the ports in any single cycle, so only the bench scenarios show its content. Those scenarios cover the restart on each frame start, continuation across idle gaps, position tracking while bypassed, the divergence under a corrupted polynomial and the round trip through a second pass. The bench compares every output word with a bit-serial model of the recurrence over frames of every length from 1 to 16 words, with random gaps and control settings.

// File: rtl/otn_scr_pkg.sv
package otn_scr_pkg;

   localparam int unsigned LFSR_W = 16;

   typedef logic [LFSR_W-1:0] lfsr_t;

   // feedback tap masks: bit i set means S[i] enters the XOR
   // nominal 1 + x + x^3 + x^12 + x^16 -> S[15], S[11], S[2], S[0]
   localparam lfsr_t TAPS_NOMINAL = 16'h8805;
   // diagnostic variant without the x^3 term (S[2])
   localparam lfsr_t TAPS_CORRUPT = 16'h8801;
   localparam lfsr_t SEED_ONES    = '1;

endpackage

// File: rtl/otn_scr_lfsr_adv.sv
module otn_scr_lfsr_adv
   import otn_scr_pkg::*;
#(
   parameter int unsigned NBITS = 64
) (
   input  lfsr_t             st_in,
   input  lfsr_t             taps,
   output logic [NBITS-1:0]  key,
   output lfsr_t             st_out
);

   lfsr_t walk;

   // NBITS serial steps unrolled into one combinational cone
   always_comb begin
      walk = st_in;
      key  = '0;
      for (int i = 0; i < int'(NBITS); i++) begin
         key[NBITS-1-i] = walk[LFSR_W-1];
         walk = {walk[LFSR_W-2:0], ^(walk & taps)};
      end
      st_out = walk;
   end

endmodule

// File: rtl/otn_scr_keygen.sv
module otn_scr_keygen
   import otn_scr_pkg::*;
#(
   parameter int unsigned DATA_W      = 64,
   parameter int unsigned ALIGN_BYTES = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic              sof,
   input  logic              corrupt,
   output logic [DATA_W-1:0] key_word
);

   localparam int unsigned PROT_BITS = 8 * ALIGN_BYTES;
   localparam int unsigned SOF_BITS  = DATA_W - PROT_BITS;

   lfsr_t               state_q;
   lfsr_t               taps;
   lfsr_t               run_nxt;
   lfsr_t               sof_nxt;
   logic [DATA_W-1:0]   run_key;
   logic [SOF_BITS-1:0] sof_key;

   assign taps = corrupt ? TAPS_CORRUPT : TAPS_NOMINAL;

   // continuation from the stored state: a full word of key bits
   otn_scr_lfsr_adv #(.NBITS(DATA_W)) u_run (
      .st_in  (state_q),
      .taps   (taps),
      .key    (run_key),
      .st_out (run_nxt)
   );

   // restart from the seed: only the bits after the alignment bytes
   otn_scr_lfsr_adv #(.NBITS(SOF_BITS)) u_sof (
      .st_in  (SEED_ONES),
      .taps   (taps),
      .key    (sof_key),
      .st_out (sof_nxt)
   );

   generate
      if (PROT_BITS == 0) begin : g_no_prot
         assign key_word = sof ? sof_key : run_key;
      end else begin : g_prot
         assign key_word = sof ? {{PROT_BITS{1'b0}}, sof_key} : run_key;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEED_ONES;
      end else if (adv) begin
         state_q <= sof ? sof_nxt : run_nxt;
      end
   end

endmodule

// File: rtl/otn_frame_scrambler.sv
module otn_frame_scrambler #(
   parameter int unsigned DATA_W      = 64,
   parameter int unsigned ALIGN_BYTES = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_sof,
   input  logic              in_valid,
   input  logic              scr_en,
   input  logic              corrupt_en,
   output logic [DATA_W-1:0] out_data,
   output logic              out_sof,
   output logic              out_valid
);

   localparam int unsigned WORD_BYTES = DATA_W / 8;

   generate
      if ((DATA_W % 8) != 0) begin : g_bad_width
         $error("otn_frame_scrambler: DATA_W must be a whole number of bytes");
      end
      if (ALIGN_BYTES >= WORD_BYTES) begin : g_bad_align
         $error("otn_frame_scrambler: ALIGN_BYTES must leave scrambled bits in the first word");
      end
   endgenerate

   logic [DATA_W-1:0] key_word;
   logic              apply;

   otn_scr_keygen #(
      .DATA_W      (DATA_W),
      .ALIGN_BYTES (ALIGN_BYTES)
   ) u_keygen (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (in_valid),
      .sof      (in_sof),
      .corrupt  (corrupt_en),
      .key_word (key_word)
   );

   assign apply = in_valid & scr_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_data  <= '0;
         out_sof   <= 1'b0;
         out_valid <= 1'b0;
      end else begin
         out_data  <= apply ? (in_data ^ key_word) : in_data;
         out_sof   <= in_sof & in_valid;
         out_valid <= in_valid;
      end
   end

endmodule

// File: rtl/otn_frame_scrambler_chk.sv
module otn_frame_scrambler_chk #(
   parameter int unsigned DATA_W      = 64,
   parameter int unsigned ALIGN_BYTES = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] in_data,
   input logic              in_sof,
   input logic              in_valid,
   input logic              scr_en,
   input logic [DATA_W-1:0] out_data,
   input logic              out_sof,
   input logic              out_valid
);

   localparam int unsigned PROT_BITS = 8 * ALIGN_BYTES;

   // high once the previous edge was already out of reset
   logic armed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   // R4
   p_valid_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (out_valid == $past(in_valid)));

   // R4
   p_sof_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (out_sof == $past(in_sof && in_valid)));

   // R5
   p_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(!scr_en)) |-> (out_data == $past(in_data)));

   // R3
   p_idle_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(!in_valid)) |-> (out_data == $past(in_data)));

   generate
      if (PROT_BITS > 0) begin : g_prot_chk
         // R2
         p_align_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (armed && $past(in_sof && in_valid)) |->
            (out_data[DATA_W-1 -: PROT_BITS] == $past(in_data[DATA_W-1 -: PROT_BITS])));
      end
   endgenerate

endmodule

bind otn_frame_scrambler otn_frame_scrambler_chk #(
   .DATA_W      (DATA_W),
   .ALIGN_BYTES (ALIGN_BYTES)
) u_chk (.*);

// File: tb/otn_frame_scrambler_tb.sv
`timescale 1ns/1ps
module otn_frame_scrambler_tb;

   logic        clk;
   logic        rst_n;
   logic [63:0] in_data;
   logic        in_sof;
   logic        in_valid;
   logic        scr_en;
   logic        corrupt_en;
   logic [63:0] out_data;
   logic        out_sof;
   logic        out_valid;

   int          n_tests;
   int          n_fail;
   bit          done;
   logic [15:0] m_st;
   logic [31:0] lcg;
   logic [63:0] last_out;
   logic [63:0] orig [16];
   logic [63:0] scr  [16];

   otn_frame_scrambler u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_data    (in_data),
      .in_sof     (in_sof),
      .in_valid   (in_valid),
      .scr_en     (scr_en),
      .corrupt_en (corrupt_en),
      .out_data   (out_data),
      .out_sof    (out_sof),
      .out_valid  (out_valid)
   );

   initial clk = 1'b0;
   always #10 clk = ~clk;

   function automatic logic [31:0] rnd();
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      return lcg;
   endfunction

   // bit-serial recurrence from R1 / R6; earliest bit lands highest
   function automatic logic [63:0] gen(input int n, input logic cor, inout logic [15:0] st);
      logic [63:0] k;
      logic        fb;
      k = '0;
      for (int i = 0; i < n; i++) begin
         k[n-1-i] = st[15];
         fb = st[15] ^ st[11] ^ st[0] ^ (cor ? 1'b0 : st[2]);
         st = {st[14:0], fb};
      end
      return k;
   endfunction

   task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // drive one word at a falling edge, check the registered result one clock later
   task automatic word(input logic [63:0] d, input logic s, input logic v,
                       input logic en, input logic cor, input string req);
      logic [63:0] k;
      logic [63:0] exp;
      in_data = d; in_sof = s; in_valid = v; scr_en = en; corrupt_en = cor;
      k = '0;
      if (v) begin
         if (s) begin
            m_st = 16'hFFFF;
            k = {48'h0, gen(16, cor, m_st)[15:0]};
         end else begin
            k = gen(64, cor, m_st);
         end
      end
      exp = (v && en) ? (d ^ k) : d;
      @(negedge clk);
      last_out = out_data;
      n_tests++;
      if (out_data !== exp || out_valid !== v || out_sof !== (s & v)) begin
         n_fail++;
         $display("FAIL %s: actual data %h valid %b sof %b expected data %h valid %b sof %b",
                  req, out_data, out_valid, out_sof, exp, v, s & v);
      end
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] nom;
      logic [63:0] knom;
      n_tests = 0; n_fail = 0; done = 1'b0; lcg = 32'h1234_5678;
      in_data = '0; in_sof = 0; in_valid = 0; scr_en = 0; corrupt_en = 0;
      rst_n = 0; m_st = 16'hFFFF;
      repeat (3) @(negedge clk);
      // R8: reset values
      check64("R8 reset", {out_data[63:2], out_sof, out_valid}, 64'h0);
      rst_n = 1;

      // R8: word before any frame start uses the seed
      word(64'h0, 0, 1, 1, 0, "R8 pre-frame word");
      check64("R8 seed top bits", {48'h0, last_out[63:48]}, 64'h000000000000FFFF);

      // R2: known frame-start word
      word(64'h0, 1, 1, 1, 0, "R2 frame start");
      check64("R2 all-zero start", last_out, 64'h000000000000FFFF);
      word(64'hA5A5_A5A5_A5A5_A5A5, 1, 1, 1, 0, "R2 start keeps alignment");
      check64("R2 alignment bytes", {16'h0, last_out[63:16]}, {16'h0, 48'hA5A5_A5A5_A5A5});

      // R1: keystream exposure with zero data
      for (int i = 0; i < 8; i++) word(64'h0, 0, 1, 1, 0, "R1 zero payload");

      // R3: gaps, with a frame start raised on an idle cycle
      word(64'hFFFF_FFFF_FFFF_FFFF, 1, 1, 1, 0, "R3 start");
      word(64'h0123_4567_89AB_CDEF, 0, 1, 1, 0, "R3 word");
      word(64'hDEAD_BEEF_0000_1111, 1, 0, 1, 0, "R3 idle sof ignored");
      word(64'h0, 0, 0, 1, 0, "R3 idle");
      word(64'h0, 0, 1, 1, 0, "R3 resume after gap");

      // R5: bypass in mid-frame, then enable again
      word(64'h0, 1, 1, 1, 0, "R5 start");
      word(64'h5555_AAAA_5555_AAAA, 0, 1, 0, 0, "R5 bypass");
      word(64'h0, 0, 1, 0, 0, "R5 bypass");
      word(64'h0, 0, 1, 1, 0, "R5 re-enabled keeps position");

      // R6: corrupted polynomial diverges from nominal
      word(64'h0, 1, 1, 1, 1, "R6 start corrupt");
      word(64'h0, 0, 1, 1, 1, "R6 corrupt");
      nom = 16'hFFFF;
      knom = gen(16, 0, nom);
      knom = gen(64, 0, nom);
      knom = gen(64, 0, nom);
      word(64'h0, 0, 1, 1, 1, "R6 corrupt");
      n_tests++;
      if (last_out === knom) begin
         n_fail++;
         $display("FAIL R6: actual %h expected a value other than %h", last_out, knom);
      end
      word(64'h0, 0, 1, 1, 0, "R6 released");

      // R7: round trip
      for (int i = 0; i < 10; i++) begin
         orig[i] = {rnd(), rnd()};
         word(orig[i], i == 0, 1, 1, 0, "R7 first pass");
         scr[i] = last_out;
      end
      for (int i = 0; i < 10; i++) begin
         word(scr[i], i == 0, 1, 1, 0, "R7 second pass");
         check64("R7 recovered", last_out, orig[i]);
      end

      // sweep: every frame length 1..16, random gaps and controls (R1 R3 R5 R6)
      for (int len = 1; len <= 16; len++) begin
         for (int rep = 0; rep < 4; rep++) begin
            for (int w = 0; w < len; w++) begin
               logic [31:0] r;
               r = rnd();
               if (r[3:0] == 4'h0) word({rnd(), rnd()}, r[4], 0, r[5], r[6], "R3 sweep idle");
               word({rnd(), rnd()}, w == 0, 1, r[8:7] != 2'b00, r[12:9] == 4'h0, "R1 sweep");
            end
         end
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule